// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Register

This block sits in front of a two-channel 12-bit converter. It has one 12-bit data bus that both channels share, a line that picks the channel, and two active-low strobes. The write strobe loads a channel's staging register. The load strobe moves both staging values into the output registers at the same moment. Each channel therefore holds its code at two levels. Software can stage new codes for both channels and then change both analog outputs together.

The three control lines and the data bus pass through a two-flop synchronizer on the system clock. All register activity happens on clock edges while a synchronized strobe condition holds. When both strobes are low, the selected channel becomes transparent: the bus value reaches its output code directly. A rising edge on the synchronized load strobe performs a final capture on the following clock. Three update sequences are supported:

- A two-cycle sequence, in which the second write overlaps the load strobe.
- A three-cycle sequence, which ends with a load-only step.
- A sequence with the load strobe tied to the channel-select line, which requires channel B to be written first.

Top module: `dual_dac_front`

## Requirements
- R1: A synchronous active-high `rst` clears both staging registers, both output registers and both output codes to zero.
- R2: With `wr_n` low and `ld_n` high, only the selected channel's staging register takes the bus. `sel_b` = 0 selects channel A and `sel_b` = 1 selects channel B. The other staging register and both output codes hold.
- R3: With `wr_n` high and `ld_n` low, both output registers take their own channel's staging value together, and both staging registers hold.
- R4: With both strobes low, the selected channel's staging and output registers both follow the bus. The unselected output register takes its channel's held staging value.
- R5: With both strobes high and no load rising edge pending, all four registers hold, whatever the bus carries.
- R6: When `ld_n` rises, the output registers keep the value they held just before the rising edge. A bus change that arrives together with the rising edge does not reach the outputs.
- R7: Two-cycle sequence: write one channel, then write the other channel while `ld_n` is low. Both codes then show the new values.
- R8: Three-cycle sequence: write A, write B, then assert only `ld_n`. Both codes update together only in that third step.
- R9: With `ld_n` driven equal to `sel_b`, writing B first (`sel_b` = 1) and then A (`sel_b` = 0) leaves both codes correct after the strobes return high.
- R10: A pin change reaches the output codes on the third rising clock edge after it is applied: two synchronizer stages, then the register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 12 | Shared data bus |
| sel_b | input | 1 | Channel select: 0 = A, 1 = B |
| wr_n | input | 1 | Staging write strobe, active low |
| ld_n | input | 1 | Output load strobe, active low |
| code_a | output | 12 | Channel A output register |
| code_b | output | 12 | Channel B output register |

## Verification
The bench targets the following corner cases:

- **Transparent mode.** Here a design that let the unselected output keep its old value, instead of loading its staging value, would leave a stale code on that channel.
- **Simultaneous release.** The bus changes on the same step that both strobes rise. A design that captured late would show the new bus value instead of the last transparent one.
- **Tied-strobe ordering and write-only steps.** A design that wrote both staging registers, or that let a write disturb an output code, would be exposed by a later load-only step.
- **Latency.** This is sampled one edge before and one edge after the expected output change. An extra or a missing pipeline stage is caught.

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_data,
  input  logic         sel_b,
  input  logic         wr_n,
  input  logic         ld_n,
  output logic [W-1:0] code_a,
  output logic [W-1:0] code_b
);
  logic [W-1:0] dat_m, dat_s;
  logic         sel_m, sel_s, wr_m, wr_s, ld_m, ld_s, ld_q;
  logic [W-1:0] stg_a, stg_b, out_a, out_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      {dat_m, dat_s} <= '0;
      {sel_m, sel_s} <= 2'b00;
      {wr_m, wr_s, ld_m, ld_s, ld_q} <= 5'b11111;
    end else begin
      dat_m <= bus_data;  dat_s <= dat_m;
      sel_m <= sel_b;     sel_s <= sel_m;
      wr_m  <= wr_n;      wr_s  <= wr_m;
      ld_m  <= ld_n;      ld_s  <= ld_m;
      ld_q  <= ld_s;
    end
  end

  wire wr_a    = !wr_s && !sel_s;
  wire wr_b    = !wr_s &&  sel_s;
  wire ld_rise = ld_s && !ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_a <= '0; stg_b <= '0; out_a <= '0; out_b <= '0;
    end else begin
      if (wr_a) stg_a <= dat_s;
      if (wr_b) stg_b <= dat_s;
      if (!ld_s) begin
        out_a <= wr_a ? dat_s : stg_a;
        out_b <= wr_b ? dat_s : stg_b;
      end else if (ld_rise) begin
        out_a <= stg_a;
        out_b <= stg_b;
      end
    end
  end

  assign code_a = out_a;
  assign code_b = out_b;

  AST_WRITE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (!wr_s && sel_s) |=> (stg_a == $past(stg_a))); // R2
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_s |=> (stg_a == $past(stg_a) && stg_b == $past(stg_b))); // R3
  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (rst)
    (wr_s && !ld_s) |=> (out_a == $past(stg_a) && out_b == $past(stg_b))); // R3
  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (!wr_s && !ld_s && !sel_s) |=> (out_a == $past(dat_s) && out_b == $past(stg_b))); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ld_s && ld_q) |=> (out_a == $past(out_a) && out_b == $past(out_b))); // R5
  AST_RISE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ld_s && !ld_q && wr_s) |=> $stable(out_a)); // R6
endmodule

// File: tb/dual_dac_front_bench.sv
module dual_dac_front_bench;
  logic clk = 0;
  always #2 clk = ~clk;

  logic        rst, sel_b, wr_n, ld_n;
  logic [11:0] bus_data, code_a, code_b;
  int checks = 0, errors = 0;
  logic [11:0] m_ia, m_ib, m_da, m_db;
  logic        m_ld;

  dual_dac_front u_dual_dac_front (.clk(clk), .rst(rst), .bus_data(bus_data),
    .sel_b(sel_b), .wr_n(wr_n), .ld_n(ld_n), .code_a(code_a), .code_b(code_b));

  task automatic chk(string r, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", r, got, exp);
    end
  endtask

  task automatic step(string r, logic s, logic w, logic l, logic [11:0] d);
    @(negedge clk);
    sel_b = s; wr_n = w; ld_n = l; bus_data = d;
    if (!m_ld && l) begin m_da = m_ia; m_db = m_ib; end
    if (!w) begin if (s) m_ib = d; else m_ia = d; end
    if (!l) begin m_da = m_ia; m_db = m_ib; end
    m_ld = l;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({r, " code_a"}, code_a, m_da);
    chk({r, " code_b"}, code_b, m_db);
  endtask

  task automatic t_reset;
    rst = 1; sel_b = 0; wr_n = 1; ld_n = 1; bus_data = 12'hABC;
    m_ia = 0; m_ib = 0; m_da = 0; m_db = 0; m_ld = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 code_a", code_a, 0);
    chk("R1 code_b", code_b, 0);
  endtask

  task automatic t_modes;
    step("R2 write A", 0, 0, 1, 12'h123);
    step("R2 write B", 1, 0, 1, 12'h456);
    step("R5 idle bus change", 0, 1, 1, 12'hFFF);
    step("R3 load", 1, 1, 0, 12'h000);
    step("R5 release", 1, 1, 1, 12'h777);
    step("R2 write A only", 0, 0, 1, 12'h9A9);
    step("R4 transparent A", 0, 0, 0, 12'h5A5);
    step("R4 transparent A follow", 0, 0, 0, 12'h3C3);
    step("R6 release with new bus", 0, 1, 1, 12'hEEE);
    step("R4 transparent B", 1, 0, 0, 12'h0F0);
    step("R6 release B", 1, 1, 1, 12'h111);
  endtask

  task automatic t_two_cycle;
    step("R7 first write", 0, 0, 1, 12'h2A1);
    step("R7 second write+load", 1, 0, 0, 12'h2B2);
    step("R7 release", 1, 1, 1, 12'h000);
  endtask

  task automatic t_three_cycle;
    step("R8 write A", 0, 0, 1, 12'h3A3);
    step("R8 write B", 1, 0, 1, 12'h3B3);
    step("R8 load", 0, 1, 0, 12'h000);
    step("R8 release", 0, 1, 1, 12'h000);
  endtask

  task automatic t_tied;
    step("R9 write B", 1, 0, 1, 12'h4B4);
    step("R9 write A", 0, 0, 0, 12'h4A4);
    step("R9 release", 1, 1, 1, 12'h000);
  endtask

  task automatic t_latency;
    step("R10 stage A", 0, 0, 1, 12'h6A6);
    @(negedge clk); ld_n = 0; wr_n = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 before third edge", code_a, m_da);
    @(posedge clk); @(negedge clk);
    chk("R10 at third edge", code_a, 12'h6A6);
    m_da = m_ia; m_db = m_ib; m_ld = 0;
    step("R10 release", 0, 1, 1, 12'h000);
  endtask

  initial begin
    t_reset;
    t_modes;
    t_two_cycle;
    t_three_cycle;
    t_tied;
    t_latency;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule